// File: doc/BRIEF.md
# Input Change Detector with Interrupt

This block watches a small group of general-purpose input pins. It records a sticky change flag for each pin whenever the pin's level toggles. Software reads one status byte that holds the sticky change flags next to the pins' present levels. That read also clears the flags. A per-pin enable vector selects which pins may raise a summary "input changed" bit. The summary bit sits at the top of an eight-bit interrupt status word, alongside seven other interrupt sources that arrive as plain inputs.

The status word is always visible unmasked. A separate eight-bit mask selects which of its bits pull the active-low interrupt line. Every pin passes through a multi-flop synchronizer before edge detection. All outputs come from registers.

Top module: `pin_change_irq`

## Requirements
- R1: The status byte `stat_q_o` carries the change flags of pins 3..0 in bits 7..4 and the levels of pins 3..0 in bits 3..0. Pin n maps to bit n+4 for its flag and to bit n for its level. It updates on the clock edge that samples `stat_rd_i` high and holds between reads.
- R2: The level bits are not sticky. They show the synchronized pin levels at the edge where the read is sampled.
- R3: A low-to-high or high-to-low toggle on a pin sets that pin's change flag. The flag is set on the third rising edge after the pin changes (two synchronizer flops, then detection). Several pins toggling together set all of their flags.
- R4: A read clears every change flag. The byte returned by that read still shows the flags as they stood before the clear.
- R5: The same read clears the summary bit `isr_o[7]`. The bit reads 0 from the edge that samples the read.
- R6: `isr_o[7]` becomes 1 only on an edge where a pin with `pin_en_i` = 1 registers a toggle. Toggles on disabled pins leave it unchanged.
- R7: `irq_n_o` is 0 exactly when some bit of `isr_o` is 1 and the same bit of the mask that was present on that edge is 1. The line updates on the same edge as `isr_o`.
- R8: `isr_o` is not masked. Bits 6..0 repeat `other_src_i` one cycle later. In order from bit 6 down to bit 0, those inputs are: break B, receive-ready B, transmit-ready B, counter ready, break A, receive-ready A, transmit-ready A.
- R9: While reset is high, `isr_o` and `stat_q_o` are 0 and `irq_n_o` is 1.
- R10: A toggle that registers on the same edge as a clearing read is not lost. Its flag is set after the read, and the summary bit is set as well if the pin is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | NPINS | Asynchronous input pins |
| pin_en_i | input | NPINS | Per-pin enable for the summary bit |
| stat_rd_i | input | 1 | One-cycle strobe that reads and clears the change status |
| stat_q_o | output | 2*NPINS | Change flags (upper half) and levels (lower half) |
| other_src_i | input | 7 | Remaining interrupt sources, status bits 6..0 |
| irq_mask_i | input | 8 | Interrupt mask, one bit per status bit |
| isr_o | output | 8 | Unmasked interrupt status |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A wrong flag or summary register shows up at the ports within three edges of a pin toggle. The next read returns a wrong upper nibble, and `isr_o[7]` or `irq_n_o` disagrees with the enable vector. A clear that fails appears on a second, back-to-back read as leftover flags. A lost coincident event appears as an empty flag on the read that follows. Because each pin is swept against every enable vector, a swapped bit position or a wrong enable gate shows up within one sweep step.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int ISR_W      = 8;
  localparam int OTHER_W    = ISR_W - 1;
  localparam int BIT_PINCHG = 7;
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pci_edge_flags.sv
module pci_edge_flags #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] en_i,
  input  logic             clr_i,
  output logic [NPINS-1:0] chg_o,
  output logic [NPINS-1:0] flags_o,
  output logic             sum_o,
  output logic             sum_next_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] flags_q;
  logic             sum_q;
  logic [NPINS-1:0] flags_next;

  assign chg_o      = lvl_i ^ prev_q;
  // a fresh toggle wins over the clearing read
  assign flags_next = (flags_q & ~{NPINS{clr_i}}) | chg_o;
  assign sum_next_o = (sum_q & ~clr_i) | (|(chg_o & en_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      flags_q <= flags_next;
      sum_q   <= sum_next_o;
    end
  end

  assign flags_o = flags_q;
  assign sum_o   = sum_q;
endmodule

// File: rtl/pci_irq_merge.sv
module pci_irq_merge
  import pci_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sum_next_i,
  input  logic [OTHER_W-1:0] other_i,
  input  logic [ISR_W-1:0]   mask_i,
  output logic [OTHER_W-1:0] other_o,
  output logic               irq_n_o
);
  logic [ISR_W-1:0] isr_next;
  logic [OTHER_W-1:0] other_q;
  logic irq_n_q;

  assign isr_next = {sum_next_i, other_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      other_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      other_q <= other_i;
      irq_n_q <= ~|(isr_next & mask_i);
    end
  end

  assign other_o = other_q;
  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pci_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPINS-1:0]     pins_i,
  input  logic [NPINS-1:0]     pin_en_i,
  input  logic                 stat_rd_i,
  output logic [2*NPINS-1:0]   stat_q_o,
  input  logic [OTHER_W-1:0]   other_src_i,
  input  logic [ISR_W-1:0]     irq_mask_i,
  output logic [ISR_W-1:0]     isr_o,
  output logic                 irq_n_o
);
  logic [NPINS-1:0]   lvl_w;
  logic [NPINS-1:0]   chg_w;
  logic [NPINS-1:0]   flags_w;
  logic               sum_w;
  logic               sum_next_w;
  logic [OTHER_W-1:0] other_w;
  logic [2*NPINS-1:0] stat_q;

  pci_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(lvl_w)
  );

  pci_edge_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst(rst), .lvl_i(lvl_w), .en_i(pin_en_i), .clr_i(stat_rd_i),
    .chg_o(chg_w), .flags_o(flags_w), .sum_o(sum_w), .sum_next_o(sum_next_w)
  );

  pci_irq_merge u_merge (
    .clk(clk), .rst(rst), .sum_next_i(sum_next_w), .other_i(other_src_i),
    .mask_i(irq_mask_i), .other_o(other_w), .irq_n_o(irq_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else if (stat_rd_i) stat_q <= {flags_w, lvl_w};
  end

  assign stat_q_o = stat_q;
  assign isr_o    = {sum_w, other_w};
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pin_en_i,
  input logic             stat_rd_i,
  input logic [6:0]       other_src_i,
  input logic [7:0]       irq_mask_i,
  input logic [7:0]       isr_o,
  input logic             irq_n_o,
  input logic [NPINS-1:0] chg,
  input logic [NPINS-1:0] flags
);
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (isr_o == 8'h00 && irq_n_o));

  a_r7_irq_follows_mask: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_n_o == !(|(isr_o & $past(irq_mask_i)))));

  a_r8_other_passthrough: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (isr_o[6:0] == $past(other_src_i)));

  a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((flags & $past(chg)) == $past(chg)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && chg == '0) |=> (flags == '0));

  a_r5_read_clears_sum: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !(|(chg & pin_en_i))) |=> !isr_o[7]);

  a_r6_sum_needs_enabled: assert property (@(posedge clk) disable iff (rst)
    (!(|(chg & pin_en_i)) && !rst) |=> !$rose(isr_o[7]));

  a_r10_keep_coincident: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && (|(chg & pin_en_i))) |=> isr_o[7]);
endmodule

bind pin_change_irq pin_change_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pin_en_i(pin_en_i), .stat_rd_i(stat_rd_i),
  .other_src_i(other_src_i), .irq_mask_i(irq_mask_i), .isr_o(isr_o),
  .irq_n_o(irq_n_o), .chg(chg_w), .flags(flags_w)
);

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pins = '0;
  logic [3:0] en = '0;
  logic       rd = 1'b0;
  logic [7:0] stat;
  logic [6:0] other = '0;
  logic [7:0] mask = '0;
  logic [7:0] isr;
  logic       irq_n;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rst(rst), .pins_i(pins), .pin_en_i(en), .stat_rd_i(rd),
    .stat_q_o(stat), .other_src_i(other), .irq_mask_i(mask),
    .isr_o(isr), .irq_n_o(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    tick(1);
    rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    tick(3);
    // R9: reset state
    chk("R9 isr", isr, 8'h00);
    chk("R9 irq_n", irq_n, 1'b1);
    chk("R9 stat", stat, 8'h00);
    rst = 1'b0;
    tick(2);

    // R3 R6 R7 R1 R5 R4 R2: every pin against every enable vector
    mask = 8'h80;
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 16; e++) begin
        en = e[3:0];
        pins[p] = ~pins[p];
        tick(3);
        chk("R6 sum", isr[7], e[p]);
        chk("R7 irq_n", irq_n, !e[p]);
        do_read();
        chk("R1 R3 stat", stat, {4'(1 << p), pins});
        chk("R5 sum cleared", isr[7], 1'b0);
        do_read();
        chk("R4 R2 reread", stat, {4'h0, pins});
      end
    end

    // R3: several pins toggling together
    en = 4'h0;
    for (int v = 1; v < 16; v++) begin
      pins = pins ^ v[3:0];
      tick(3);
      do_read();
      chk("R3 multi", stat, {v[3:0], pins});
      chk("R6 disabled", isr[7], 1'b0);
    end

    // R10: toggle registers on the same edge as a read
    en = 4'hF;
    pins[2] = ~pins[2];
    tick(2);
    do_read();
    chk("R10 read sees old", stat[7:4], 4'h0);
    chk("R10 sum kept", isr[7], 1'b1);
    do_read();
    chk("R10 flag kept", stat[7:4], 4'h4);
    chk("R10 sum then clear", isr[7], 1'b0);

    // R8 R7: other sources against masks, unmasked status
    en = 4'h0;
    for (int o = 0; o < 128; o++) begin
      other = o[6:0];
      mask = 8'((o * 37 + 11) & 8'hFF);
      tick(1);
      chk("R8 isr", isr, {1'b0, o[6:0]});
      chk("R7 irq", irq_n, !(|({1'b0, o[6:0]} & mask)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule